// File: doc/BRIEF.md
# Receive, Transmit and Synthesizer Power-State Controller

This block decides, cycle by cycle, whether the receive chain, the transmit chain and the synthesizer (PLL) section of a radio front end are powered, and it controls three general-purpose pads. The inputs are a set of configuration bits from a programming register, a chip-enable pin, a synthesizer power-down pin, and the levels read back from the pads. The outputs are one enable per section, an output enable and an output value per pad, and a flag that forces the charge-pump output into high impedance.

A two-bit mode field chooses who owns the receive and transmit power control. In register mode the configuration bits decide and all three pads are driven from register bits. In pin mode, pads 1 and 2 stop driving and are read as power-down inputs for the receive and transmit chains, while pad 0 keeps driving its register bit. The two remaining mode codes are test codes that switch every section off and release every pad. Chip enable and the synthesizer power-down pin act above every mode. All pin inputs pass through a two-flop synchronizer before they reach the enables.

Top module: `pwr_mode_ctl`

## Requirements
- R1: With the synchronized chip enable low, `rx_en_o`, `tx_en_o` and `pll_en_o` are 0 and `gpo_oe_o` is 3'b000, whatever the configuration bits and mode.
- R2: With the synchronized `pll_pd_i` high, `pll_en_o` is 0 in every mode; with it low, chip enable high and a non-test mode, `pll_en_o` is 1.
- R3: In register mode (`mode_sel_i` = 2'b00) with chip enable high, `rx_en_o` equals the inverse of `rx_sw_off_i` and `tx_en_o` equals the inverse of `tx_sw_off_i` (1 in the off bit means powered down).
- R4: In register mode with chip enable high, `gpo_oe_o` is 3'b111 and `gpo_o` equals `gpo_val_i` bit for bit.
- R5: In pin mode (`mode_sel_i` = 2'b11) with chip enable high, `rx_en_o` is the inverse of the synchronized `gpo_pin_i[1]` and `tx_en_o` is the inverse of the synchronized `gpo_pin_i[2]`; `rx_sw_off_i` and `tx_sw_off_i` have no effect.
- R6: In pin mode with chip enable high, `gpo_oe_o` is 3'b001 and `gpo_o[0]` equals `gpo_val_i[0]`.
- R7: In the test modes (`mode_sel_i` = 2'b01 or 2'b10) all three section enables are 0 and `gpo_oe_o` is 3'b000.
- R8: A change on `chip_en_i`, `pll_pd_i` or a pad used as a power-down input reaches the enables on the second rising clock edge after it, not on the first.
- R9: `cp_tri_o` is 1 whenever `cp_tri_cfg_i` is 1 or `pll_en_o` is 0, and 0 otherwise.
- R10: While `rst_ni` is low, all section enables and pad output enables are 0 and `cp_tri_o` is 1.
- R11: Every pad whose output enable is 0 has its `gpo_o` bit at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| chip_en_i | input | 1 | Chip enable pin, low powers everything down |
| pll_pd_i | input | 1 | Synthesizer power-down pin, high powers the PLL down |
| mode_sel_i | input | 2 | 00 register mode, 11 pin mode, 01/10 test |
| rx_sw_off_i | input | 1 | Register bit: 1 powers the receive chain down |
| tx_sw_off_i | input | 1 | Register bit: 1 powers the transmit chain down |
| gpo_val_i | input | 3 | Register bits for the pad output values |
| cp_tri_cfg_i | input | 1 | Register bit: 1 requests charge-pump high impedance |
| gpo_pin_i | input | 3 | Levels read at the pads |
| rx_en_o | output | 1 | Receive chain enable |
| tx_en_o | output | 1 | Transmit chain enable |
| pll_en_o | output | 1 | Synthesizer section enable |
| gpo_oe_o | output | 3 | Pad output enables |
| gpo_o | output | 3 | Pad output values |
| cp_tri_o | output | 1 | Charge-pump high-impedance flag |

## Verification
The bench walks through each mode code and checks that pin mode really ignores the register off bits and releases pads 1 and 2; a design that decoded only one mode bit would keep driving the pads or follow the register in a test code. It samples pin-driven enables on the first and second edge after a pad change, catching a synchronizer with one stage too few or too many. It drives the synthesizer power-down pin in both register and pin mode and with chip enable low, so a design that let mode logic override either pin would show a live enable. The charge-pump flag is checked with the synthesizer both on and off, exposing a flag that only follows its register bit.

// File: rtl/pwr_ctl_pkg.sv
package pwr_ctl_pkg;
  typedef enum logic [1:0] {
    MODE_REG    = 2'b00,
    MODE_TST_LO = 2'b01,
    MODE_TST_HI = 2'b10,
    MODE_PIN    = 2'b11
  } pwr_mode_e;

  localparam int unsigned RX_PAD = 1;
  localparam int unsigned TX_PAD = 2;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int unsigned WIDTH   = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] src;
    if (s == 0) begin : g_first
      assign src = d_i;
    end else begin : g_next
      assign src = stage_q[s-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= RST_VAL;
      else         stage_q[s] <= src;
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/section_pwr_dec.sv
module section_pwr_dec
  import pwr_ctl_pkg::*;
(
  input  pwr_mode_e mode_i,
  input  logic      active_i,
  input  logic      pll_pd_i,
  input  logic      rx_pin_pd_i,
  input  logic      tx_pin_pd_i,
  input  logic      rx_sw_off_i,
  input  logic      tx_sw_off_i,
  output logic      reg_mode_o,
  output logic      test_mode_o,
  output logic      rx_en_o,
  output logic      tx_en_o,
  output logic      pll_en_o
);
  logic pin_mode;

  always_comb begin
    reg_mode_o  = 1'b0;
    pin_mode    = 1'b0;
    test_mode_o = 1'b0;
    unique case (mode_i)
      MODE_REG:    reg_mode_o  = 1'b1;
      MODE_PIN:    pin_mode    = 1'b1;
      default:     test_mode_o = 1'b1;
    endcase
  end

  always_comb begin
    rx_en_o = 1'b0;
    tx_en_o = 1'b0;
    if (active_i) begin
      if (reg_mode_o) begin
        rx_en_o = ~rx_sw_off_i;
        tx_en_o = ~tx_sw_off_i;
      end else if (pin_mode) begin
        rx_en_o = ~rx_pin_pd_i;
        tx_en_o = ~tx_pin_pd_i;
      end
    end
  end

  // PLL pin overrides every mode; test codes keep it off as well
  assign pll_en_o = active_i & ~pll_pd_i & ~test_mode_o;
endmodule

// File: rtl/gpo_drive.sv
module gpo_drive #(
  parameter int unsigned NUM_GPO = 3
) (
  input  logic               active_i,
  input  logic               reg_mode_i,
  input  logic               test_mode_i,
  input  logic [NUM_GPO-1:0] val_i,
  output logic [NUM_GPO-1:0] oe_o,
  output logic [NUM_GPO-1:0] out_o
);
  for (genvar g = 0; g < NUM_GPO; g++) begin : g_pad
    if (g == 0) begin : g_fixed
      assign oe_o[g] = active_i & ~test_mode_i;
    end else begin : g_shared
      // shared pads turn into power-down inputs outside register mode
      assign oe_o[g] = active_i & reg_mode_i;
    end
    assign out_o[g] = oe_o[g] & val_i[g];
  end
endmodule

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl
  import pwr_ctl_pkg::*;
#(
  parameter int unsigned NUM_GPO     = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               chip_en_i,
  input  logic               pll_pd_i,
  input  logic [1:0]         mode_sel_i,
  input  logic               rx_sw_off_i,
  input  logic               tx_sw_off_i,
  input  logic [NUM_GPO-1:0] gpo_val_i,
  input  logic               cp_tri_cfg_i,
  input  logic [NUM_GPO-1:0] gpo_pin_i,
  output logic               rx_en_o,
  output logic               tx_en_o,
  output logic               pll_en_o,
  output logic [NUM_GPO-1:0] gpo_oe_o,
  output logic [NUM_GPO-1:0] gpo_o,
  output logic               cp_tri_o
);
  // bit order of the synchronised bundle: {tx pad, rx pad, pll pd, chip en}
  localparam int unsigned NSYNC = 4;
  localparam logic [NSYNC-1:0] SYNC_RST = 4'b1110;

  logic [NSYNC-1:0] raw_pins, sync_pins;
  logic reg_mode, test_mode, pll_en;

  assign raw_pins = {gpo_pin_i[TX_PAD], gpo_pin_i[RX_PAD], pll_pd_i, chip_en_i};

  pin_sync #(
    .WIDTH  (NSYNC),
    .STAGES (SYNC_STAGES),
    .RST_VAL(SYNC_RST)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_pins),
    .q_o   (sync_pins)
  );

  section_pwr_dec u_dec (
    .mode_i      (pwr_mode_e'(mode_sel_i)),
    .active_i    (sync_pins[0]),
    .pll_pd_i    (sync_pins[1]),
    .rx_pin_pd_i (sync_pins[2]),
    .tx_pin_pd_i (sync_pins[3]),
    .rx_sw_off_i (rx_sw_off_i),
    .tx_sw_off_i (tx_sw_off_i),
    .reg_mode_o  (reg_mode),
    .test_mode_o (test_mode),
    .rx_en_o     (rx_en_o),
    .tx_en_o     (tx_en_o),
    .pll_en_o    (pll_en)
  );

  gpo_drive #(.NUM_GPO(NUM_GPO)) u_gpo (
    .active_i    (sync_pins[0]),
    .reg_mode_i  (reg_mode),
    .test_mode_i (test_mode),
    .val_i       (gpo_val_i),
    .oe_o        (gpo_oe_o),
    .out_o       (gpo_o)
  );

  assign pll_en_o = pll_en;
  assign cp_tri_o = cp_tri_cfg_i | ~pll_en;

  // pads 0..2 are required; the unused upper pads are simply not read
  if (NUM_GPO > 3) begin : g_extra_pins
    logic unused_pins;
    assign unused_pins = ^gpo_pin_i[NUM_GPO-1:3] ^ gpo_pin_i[0];
  end else begin : g_pin0
    logic unused_pin0;
    assign unused_pin0 = gpo_pin_i[0];
  end
endmodule

// File: rtl/pwr_mode_ctl_chk.sv
module pwr_mode_ctl_chk #(
  parameter int unsigned NUM_GPO = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               chip_en_i,
  input logic               pll_pd_i,
  input logic [1:0]         mode_sel_i,
  input logic               rx_sw_off_i,
  input logic               tx_sw_off_i,
  input logic               rx_en_o,
  input logic               tx_en_o,
  input logic               pll_en_o,
  input logic [NUM_GPO-1:0] gpo_oe_o,
  input logic [NUM_GPO-1:0] gpo_o,
  input logic               cp_tri_o
);
  logic [1:0] age_q;
  logic       warm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            age_q <= '0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end
  assign warm = (age_q == 2'd2);

  p_ce_off_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && !$past(chip_en_i, 2)) |-> (!rx_en_o && !tx_en_o && !pll_en_o && gpo_oe_o == '0));

  p_pll_pin_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && $past(pll_pd_i, 2)) |-> !pll_en_o);

  p_reg_mode_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && $past(chip_en_i, 2) && mode_sel_i == 2'b00)
      |-> (rx_en_o == !rx_sw_off_i && tx_en_o == !tx_sw_off_i));

  p_pin_mode_oe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_sel_i == 2'b11) |-> (gpo_oe_o[2:1] == 2'b00));

  p_test_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_sel_i == 2'b01 || mode_sel_i == 2'b10)
      |-> (!rx_en_o && !tx_en_o && !pll_en_o && gpo_oe_o == '0));

  p_cp_tri_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pll_en_o |-> cp_tri_o);

  p_idle_pad_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gpo_o & ~gpo_oe_o) == '0);

  always_comb begin
    if (!rst_ni) begin
      p_reset_r10: assert (!rx_en_o && !tx_en_o && !pll_en_o && cp_tri_o);
    end
  end
endmodule

bind pwr_mode_ctl pwr_mode_ctl_chk #(.NUM_GPO(NUM_GPO)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .chip_en_i   (chip_en_i),
  .pll_pd_i    (pll_pd_i),
  .mode_sel_i  (mode_sel_i),
  .rx_sw_off_i (rx_sw_off_i),
  .tx_sw_off_i (tx_sw_off_i),
  .rx_en_o     (rx_en_o),
  .tx_en_o     (tx_en_o),
  .pll_en_o    (pll_en_o),
  .gpo_oe_o    (gpo_oe_o),
  .gpo_o       (gpo_o),
  .cp_tri_o    (cp_tri_o)
);

// File: tb/tb_pwr_mode_ctl.sv
`timescale 1ns/1ps
module tb_pwr_mode_ctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       chip_en, pll_pd, rx_off, tx_off, cp_cfg;
  logic [1:0] mode;
  logic [2:0] gval, pins;
  logic       rx_en, tx_en, pll_en, cp_tri;
  logic [2:0] oe, gout;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwr_mode_ctl dut (
    .clk_i(clk), .rst_ni(rst_n), .chip_en_i(chip_en), .pll_pd_i(pll_pd),
    .mode_sel_i(mode), .rx_sw_off_i(rx_off), .tx_sw_off_i(tx_off),
    .gpo_val_i(gval), .cp_tri_cfg_i(cp_cfg), .gpo_pin_i(pins),
    .rx_en_o(rx_en), .tx_en_o(tx_en), .pll_en_o(pll_en),
    .gpo_oe_o(oe), .gpo_o(gout), .cp_tri_o(cp_tri)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    #2;
  endtask

  // {rx, tx, pll} packed for compact checks
  function automatic logic [7:0] ens();
    return {5'd0, rx_en, tx_en, pll_en};
  endfunction

  task automatic t_reset();
    chip_en = 1'b1; pll_pd = 1'b0; mode = 2'b00; rx_off = 1'b0; tx_off = 1'b0;
    gval = 3'b101; cp_cfg = 1'b0; pins = 3'b110;
    repeat (3) @(posedge clk);
    #2;
    chk("R10 enables in reset", ens(), 8'h0);
    chk("R10 oe in reset", {5'd0, oe}, 8'h0);
    chk("R10 cp_tri in reset", {7'd0, cp_tri}, 8'h1);
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic t_reg_mode();
    settle();
    chk("R3 all on", ens(), 8'h7);
    chk("R4 oe all", {5'd0, oe}, 8'h7);
    chk("R4 values", {5'd0, gout}, 8'h5);
    @(negedge clk) rx_off = 1'b1;
    settle();
    chk("R3 rx off", ens(), 8'h3);
    @(negedge clk) begin rx_off = 1'b0; tx_off = 1'b1; gval = 3'b010; end
    settle();
    chk("R3 tx off", ens(), 8'h5);
    chk("R4 values 010", {5'd0, gout}, 8'h2);
    @(negedge clk) tx_off = 1'b0;
  endtask

  task automatic t_pin_mode();
    @(negedge clk) begin
      mode = 2'b11; rx_off = 1'b1; tx_off = 1'b1; gval = 3'b111; pins = 3'b100;
    end
    settle();
    chk("R5 rx pad low tx pad high, off bits ignored", ens(), 8'h5);
    chk("R6 oe pad0 only", {5'd0, oe}, 8'h1);
    chk("R11 released pads at 0", {5'd0, gout}, 8'h1);
    @(negedge clk) begin pins = 3'b010; gval = 3'b110; end
    settle();
    chk("R5 rx pad high tx pad low", ens(), 8'h3);
    chk("R6 pad0 value follows", {5'd0, gout}, 8'h0);
    @(negedge clk) begin rx_off = 1'b0; tx_off = 1'b0; gval = 3'b101; end
  endtask

  task automatic t_test_modes();
    for (int m = 1; m <= 2; m++) begin
      @(negedge clk) begin mode = 2'(m); pins = 3'b000; end
      settle();
      chk("R7 test enables", ens(), 8'h0);
      chk("R7 test oe", {5'd0, oe}, 8'h0);
      chk("R9 cp_tri with pll off", {7'd0, cp_tri}, 8'h1);
    end
  endtask

  task automatic t_pll_pin();
    @(negedge clk) begin mode = 2'b00; pll_pd = 1'b1; end
    settle();
    chk("R2 pll down reg mode", ens(), 8'h6);
    chk("R9 cp_tri pll down", {7'd0, cp_tri}, 8'h1);
    @(negedge clk) begin mode = 2'b11; pins = 3'b000; end
    settle();
    chk("R2 pll down pin mode", ens(), 8'h6);
    @(negedge clk) begin pll_pd = 1'b0; mode = 2'b00; end
    settle();
    chk("R2 pll up", ens(), 8'h7);
    chk("R9 cp_tri released", {7'd0, cp_tri}, 8'h0);
    @(negedge clk) cp_cfg = 1'b1;
    settle();
    chk("R9 cp_tri by register", {7'd0, cp_tri}, 8'h1);
    @(negedge clk) cp_cfg = 1'b0;
  endtask

  task automatic t_chip_en();
    @(negedge clk) chip_en = 1'b0;
    settle();
    chk("R1 ce low enables", ens(), 8'h0);
    chk("R1 ce low oe", {5'd0, oe}, 8'h0);
    @(negedge clk) mode = 2'b11;
    settle();
    chk("R1 ce low pin mode", ens(), 8'h0);
    @(negedge clk) mode = 2'b00;
  endtask

  task automatic t_latency();
    // chip enable still low here
    @(negedge clk) chip_en = 1'b1;
    @(posedge clk); #2;
    chk("R8 ce after one edge", ens(), 8'h0);
    @(posedge clk); #2;
    chk("R8 ce after two edges", ens(), 8'h7);
    @(negedge clk) begin mode = 2'b11; pins = 3'b000; end
    settle();
    @(negedge clk) pins = 3'b010;
    @(posedge clk); #2;
    chk("R8 rx pad after one edge", {7'd0, rx_en}, 8'h1);
    @(posedge clk); #2;
    chk("R8 rx pad after two edges", {7'd0, rx_en}, 8'h0);
  endtask

  initial begin
    t_reset();
    t_reg_mode();
    t_pin_mode();
    t_test_modes();
    t_pll_pin();
    t_chip_en();
    t_latency();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule